// File: doc/BRIEF.md
# Subvector Element Pack/Unpack Mover

This block is a sequencer that copies elements between two views of a small register file. In one view every register holds one element. In the other view one register holds a group of 1 to 4 sub-elements placed side by side in lanes. Only one operand is grouped. In pack mode the source side is ungrouped and each destination register is built from a run of source registers. In unpack mode the grouping is on the source side and each source register is spread over a run of destination registers. Each side has its own element width. Every sub-element is converted from the source width to the destination width by zero-extension or truncation, or by unsigned or signed saturation.

A controller drives the operation fields and pulses `start`. The block then walks the groups in increasing order through a single read port and a single write port on the register file. It handles one sub-element per clock. A per-group predicate mask can skip whole groups. The operation stops early with an error flag if a register index runs past the end of the file.

Top module: `subvec_pack_mover`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `rf_we` are all 0.
- R2: Pack mode (`unpack`=0). For each group i and lane j, destination register `dst_base`+i receives the converted value of source register `src_base`+i*SUBVL+j at bit offset j times the destination width. Bits above the filled lanes are 0; for example, three byte lanes leave bits 31:24 at zero. Lanes that start at bit 32 or above are dropped.
- R3: Unpack mode (`unpack`=1). Destination register `dst_base`+i*SUBVL+j receives the converted lane j of source register `src_base`+i, taken from bit offset j times the source width. A lane that starts at bit 32 or above reads as 0. Bits above the destination width are 0.
- R4: `subvl_m1` code c selects SUBVL=c+1. Code 0 gives a plain element-by-element move.
- R5: Width codes are 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits. With `sat_mode` 0 or 3, each source value (its low source-width bits) is zero-extended or truncated to the destination width.
- R6: `sat_mode` 1 clamps the unsigned source value to the range 0 to 2^dw-1. `sat_mode` 2 reads the source as signed, clamps it to the signed range of the destination width, and sign-extends when widening. The result is kept in the low dw bits.
- R7: When bit i of `pred_mask` is 0, group i performs no write. The destination registers of that group keep their values.
- R8: Groups are handled in increasing order, and sub-elements within a group in increasing order. Each read sees every earlier write of the same run. An enabled group takes one clock per sub-element and a skipped group takes one clock. `busy` is high for exactly those clocks, starting the cycle after the accepted `start`. `done` is a one-cycle pulse in the cycle after `busy` falls. With a vector length of 0, `done` pulses one cycle after `start` and `busy` never rises.
- R9: A step whose source or destination index is NREG or above performs no write. In pack mode the partly built group is discarded. The run then stops: `err` goes to 1 and `done` pulses. `err` holds until the next accepted `start` clears it.
- R10: `start` is accepted only when the block is idle. All operation fields are captured at acceptance, so changes to them or to `start` during a run have no effect.
- R11: A `vec_len` above MAXVL is treated as MAXVL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation when idle |
| unpack | input | 1 | 0 = pack groups into one register, 1 = spread one register into a group |
| src_base | input | AW | First source register index |
| dst_base | input | AW | First destination register index |
| vec_len | input | VLW | Number of groups |
| subvl_m1 | input | 2 | Group size minus one |
| src_ew | input | 2 | Source element width code |
| dst_ew | input | 2 | Destination element width code |
| pred_mask | input | MAXVL | Per-group enable, bit i for group i |
| sat_mode | input | 2 | Conversion: 0/3 plain, 1 unsigned clamp, 2 signed clamp |
| rf_raddr | output | AW | Register file read index |
| rf_rdata | input | 32 | Register file read data (same cycle) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | AW | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err | output | 1 | Index ran past the file end |

## Verification
A wrong group or lane counter shows up as a data error at the next write. The bench detects it as soon as it compares the whole register file after `done`, and as a wrong count of `busy` cycles. A wrong pack accumulator also corrupts the next destination register, but only when that group's last sub-element is written, so a single-lane group can hide it. A wrong fault decision shows up in the same run, either as a premature `done` with `err` set or as an out-of-range write being missing or present in the register file image.

// File: rtl/subvec_mover_pkg.sv
package subvec_mover_pkg;
  localparam int XLEN = 32;
  localparam int SXW  = XLEN + 2;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_FIN = 2'd2} seq_state_e;

  localparam logic [1:0] SAT_UNS = 2'd1;
  localparam logic [1:0] SAT_SGN = 2'd2;

  // width code to bit count
  function automatic logic [6:0] ew_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 7'd8;
      2'd1:    return 7'd16;
      default: return 7'd32;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] low_mask(input logic [6:0] w);
    if (w >= 7'(XLEN)) return '1;
    return (XLEN'(1) << w) - XLEN'(1);
  endfunction

  // convert one sub-element from source width to destination width
  function automatic logic [XLEN-1:0] conv_lane(input logic [XLEN-1:0] v,
                                                input logic [1:0] sc,
                                                input logic [1:0] dc,
                                                input logic [1:0] sat);
    logic [6:0]             sw;
    logic [6:0]             dw;
    logic [XLEN-1:0]        src;
    logic [XLEN-1:0]        dmask;
    logic [XLEN-1:0]        res;
    logic [SXW-1:0]         wrap;
    logic [SXW-1:0]         half;
    logic signed [SXW-1:0]  sv;
    logic signed [SXW-1:0]  hi;
    logic signed [SXW-1:0]  lo;
    sw    = ew_bits(sc);
    dw    = ew_bits(dc);
    src   = v & low_mask(sw);
    dmask = low_mask(dw);
    wrap  = SXW'(1) << sw;
    half  = SXW'(1) << (dw - 7'd1);
    sv    = $signed({2'b00, src});
    if (src[sw - 7'd1]) sv = sv - $signed(wrap);
    hi    = $signed(half - SXW'(1));
    lo    = -$signed(half);
    case (sat)
      SAT_UNS: res = (src > dmask) ? dmask : src;
      SAT_SGN: begin
        if (sv > hi)      res = hi[XLEN-1:0];
        else if (sv < lo) res = lo[XLEN-1:0];
        else              res = sv[XLEN-1:0];
        res = res & dmask;
      end
      default: res = src & dmask;
    endcase
    return res;
  endfunction
endpackage

// File: rtl/subvec_seq.sv
module subvec_seq #(
  parameter int MAXVL = 16,
  parameter int VIW   = 4,
  parameter int VLW   = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl_in,
  input  logic [2:0]     svl,
  input  logic           pred_bit,
  input  logic           range_fault,
  output logic           accept,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [VIW-1:0] grp,
  output logic [1:0]     sub,
  output logic           last_sub,
  output logic           step_fire,
  output logic           grp_skip,
  output logic           fault_hit
);
  import subvec_mover_pkg::*;

  seq_state_e     state;
  logic [VLW-1:0] vl_q;
  logic [VLW-1:0] vl_clamp;
  logic           running;
  logic           last_grp;

  assign vl_clamp  = (vl_in > VLW'(MAXVL)) ? VLW'(MAXVL) : vl_in;
  assign running   = (state == ST_RUN);
  assign accept    = (state == ST_IDLE) && start;
  assign busy      = running;
  assign done      = (state == ST_FIN);
  assign last_sub  = ({1'b0, sub} == (svl - 3'd1));
  assign last_grp  = (VLW'(grp) == (vl_q - VLW'(1)));
  assign grp_skip  = running && !pred_bit;
  assign fault_hit = running && pred_bit && range_fault;
  assign step_fire = running && pred_bit && !range_fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      vl_q  <= '0;
      grp   <= '0;
      sub   <= '0;
      err   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          err   <= 1'b0;
          grp   <= '0;
          sub   <= '0;
          vl_q  <= vl_clamp;
          state <= (vl_clamp == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          if (fault_hit) begin
            err   <= 1'b1;
            state <= ST_FIN;
          end else if (grp_skip || last_sub) begin
            sub <= '0;
            if (last_grp) state <= ST_FIN;
            else          grp   <= grp + VIW'(1);
          end else begin
            sub <= sub + 2'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/subvec_addr_gen.sv
module subvec_addr_gen #(
  parameter int NREG = 32,
  parameter int AW   = 5,
  parameter int VIW  = 4,
  parameter int EAW  = 12
) (
  input  logic           unpack,
  input  logic [AW-1:0]  src_base,
  input  logic [AW-1:0]  dst_base,
  input  logic [VIW-1:0] grp,
  input  logic [1:0]     sub,
  input  logic [2:0]     svl,
  output logic [EAW-1:0] rd_idx,
  output logic [EAW-1:0] wr_idx,
  output logic           range_fault
);
  logic [EAW-1:0] flat;
  logic [EAW-1:0] grp_w;

  assign grp_w = EAW'(grp);
  assign flat  = grp_w * EAW'(svl) + EAW'(sub);

  generate
    if (NREG > 0) begin : g_idx
      always_comb begin
        if (unpack) begin
          rd_idx = EAW'(src_base) + grp_w;
          wr_idx = EAW'(dst_base) + flat;
        end else begin
          rd_idx = EAW'(src_base) + flat;
          wr_idx = EAW'(dst_base) + grp_w;
        end
      end
    end
  endgenerate

  assign range_fault = (rd_idx >= EAW'(NREG)) || (wr_idx >= EAW'(NREG));
endmodule

// File: rtl/subvec_lane_unit.sv
module subvec_lane_unit (
  input  logic        unpack,
  input  logic [1:0]  sub,
  input  logic [1:0]  src_ew,
  input  logic [1:0]  dst_ew,
  input  logic [1:0]  sat_mode,
  input  logic [31:0] rdata,
  input  logic [31:0] acc,
  output logic [31:0] wdata
);
  import subvec_mover_pkg::*;

  logic [6:0]  sh_src;
  logic [6:0]  sh_dst;
  logic [31:0] lane_in;
  logic [31:0] lane_out;

  assign sh_src   = 7'(sub) * ew_bits(src_ew);
  assign sh_dst   = 7'(sub) * ew_bits(dst_ew);
  assign lane_in  = unpack ? (rdata >> sh_src) : rdata;
  assign lane_out = conv_lane(lane_in, src_ew, dst_ew, sat_mode);
  assign wdata    = unpack ? lane_out : (acc | (lane_out << sh_dst));
endmodule

// File: rtl/subvec_pack_mover.sv
module subvec_pack_mover #(
  parameter int NREG  = 32,
  parameter int MAXVL = 16,
  localparam int AW   = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int VLW  = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             unpack,
  input  logic [AW-1:0]    src_base,
  input  logic [AW-1:0]    dst_base,
  input  logic [VLW-1:0]   vec_len,
  input  logic [1:0]       subvl_m1,
  input  logic [1:0]       src_ew,
  input  logic [1:0]       dst_ew,
  input  logic [MAXVL-1:0] pred_mask,
  input  logic [1:0]       sat_mode,
  output logic [AW-1:0]    rf_raddr,
  input  logic [31:0]      rf_rdata,
  output logic             rf_we,
  output logic [AW-1:0]    rf_waddr,
  output logic [31:0]      rf_wdata,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int VIW = (MAXVL > 1) ? $clog2(MAXVL) : 1;
  localparam int EAW = AW + VIW + 3;

  // captured operation
  logic             unpack_q;
  logic [AW-1:0]    sb_q;
  logic [AW-1:0]    db_q;
  logic [2:0]       svl_q;
  logic [1:0]       sew_q;
  logic [1:0]       dew_q;
  logic [MAXVL-1:0] mask_q;
  logic [1:0]       sat_q;
  logic [31:0]      acc_q;

  // named internal events
  logic             accept;
  logic [VIW-1:0]   grp;
  logic [1:0]       sub;
  logic             last_sub;
  logic             step_fire;
  logic             grp_skip;
  logic             fault_hit;
  logic             range_fault;
  logic             pred_bit;
  logic [EAW-1:0]   rd_idx;
  logic [EAW-1:0]   wr_idx;
  logic [31:0]      wdata;

  assign pred_bit = mask_q[grp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unpack_q <= 1'b0;
      sb_q     <= '0;
      db_q     <= '0;
      svl_q    <= 3'd1;
      sew_q    <= '0;
      dew_q    <= '0;
      mask_q   <= '0;
      sat_q    <= '0;
    end else if (accept) begin
      unpack_q <= unpack;
      sb_q     <= src_base;
      db_q     <= dst_base;
      svl_q    <= {1'b0, subvl_m1} + 3'd1;
      sew_q    <= src_ew;
      dew_q    <= dst_ew;
      mask_q   <= pred_mask;
      sat_q    <= sat_mode;
    end
  end

  // pack accumulator: lanes of the group built so far
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       acc_q <= '0;
    else if (accept)                  acc_q <= '0;
    else if (step_fire && !unpack_q)  acc_q <= last_sub ? '0 : wdata;
  end

  subvec_seq #(.MAXVL(MAXVL), .VIW(VIW), .VLW(VLW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vec_len), .svl(svl_q),
    .pred_bit(pred_bit), .range_fault(range_fault), .accept(accept),
    .busy(busy), .done(done), .err(err), .grp(grp), .sub(sub),
    .last_sub(last_sub), .step_fire(step_fire), .grp_skip(grp_skip),
    .fault_hit(fault_hit)
  );

  subvec_addr_gen #(.NREG(NREG), .AW(AW), .VIW(VIW), .EAW(EAW)) u_addr (
    .unpack(unpack_q), .src_base(sb_q), .dst_base(db_q), .grp(grp), .sub(sub),
    .svl(svl_q), .rd_idx(rd_idx), .wr_idx(wr_idx), .range_fault(range_fault)
  );

  subvec_lane_unit u_lane (
    .unpack(unpack_q), .sub(sub), .src_ew(sew_q), .dst_ew(dew_q),
    .sat_mode(sat_q), .rdata(rf_rdata), .acc(acc_q), .wdata(wdata)
  );

  assign rf_raddr = rd_idx[AW-1:0];
  assign rf_waddr = wr_idx[AW-1:0];
  assign rf_wdata = wdata;
  assign rf_we    = step_fire && (unpack_q || last_sub);
endmodule

// File: rtl/subvec_pack_mover_chk.sv
module subvec_pack_mover_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic err,
  input logic rf_we,
  input logic grp_skip,
  input logic fault_hit
);
  AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> busy); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R8
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    grp_skip |-> !rf_we); // R7
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |-> !rf_we); // R9
  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |=> (!busy && err && done)); // R9
  AST_ERR_CLEARS_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(start)); // R9
endmodule

bind subvec_pack_mover subvec_pack_mover_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .rf_we(rf_we), .grp_skip(grp_skip), .fault_hit(fault_hit)
);

// File: tb/subvec_pack_mover_tb.sv
module subvec_pack_mover_tb_top;
  localparam int NREG  = 32;
  localparam int MAXVL = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        unpack = 1'b0;
  logic [4:0]  src_base = '0;
  logic [4:0]  dst_base = '0;
  logic [4:0]  vec_len = '0;
  logic [1:0]  subvl_m1 = '0;
  logic [1:0]  src_ew = '0;
  logic [1:0]  dst_ew = '0;
  logic [15:0] pred_mask = '0;
  logic [1:0]  sat_mode = '0;
  logic [4:0]  rf_raddr;
  logic [31:0] rf_rdata;
  logic        rf_we;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        busy;
  logic        done;
  logic        err;

  logic [31:0] rf     [NREG];
  logic [31:0] exp_rf [NREG];

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign rf_rdata = rf[rf_raddr];
  always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

  subvec_pack_mover #(.NREG(NREG), .MAXVL(MAXVL)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .unpack(unpack),
    .src_base(src_base), .dst_base(dst_base), .vec_len(vec_len),
    .subvl_m1(subvl_m1), .src_ew(src_ew), .dst_ew(dst_ew),
    .pred_mask(pred_mask), .sat_mode(sat_mode), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr),
    .rf_wdata(rf_wdata), .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int wbits(input int code);
    return (code == 0) ? 8 : (code == 1) ? 16 : 32;
  endfunction

  // bench-side conversion, in 64-bit integer arithmetic
  function automatic logic [31:0] ref_conv(input logic [31:0] v, input int sw,
                                           input int dw, input int mode);
    longint unsigned umax;
    longint unsigned u;
    longint s;
    longint hi;
    longint lo;
    umax = (64'd1 << dw) - 64'd1;
    u    = 64'(v) & ((64'd1 << sw) - 64'd1);
    if (mode == 1) return (u > umax) ? 32'(umax) : 32'(u);
    if (mode == 2) begin
      s  = (u >= (64'd1 << (sw - 1))) ? longint'(u) - (longint'(1) << sw) : longint'(u);
      hi = (longint'(1) << (dw - 1)) - 1;
      lo = -(longint'(1) << (dw - 1));
      if (s > hi) s = hi;
      if (s < lo) s = lo;
      return 32'(s & longint'(umax));
    end
    return 32'(u & umax);
  endfunction

  // sequential model of one operation over exp_rf
  task automatic ref_run(input int up, input int sb, input int db, input int vl,
                         input int sc, input int se, input int de,
                         input logic [15:0] m, input int sat,
                         output int steps, output bit e);
    int n;
    int sw;
    int dw;
    int ra;
    int wa;
    logic [31:0] acc;
    logic [31:0] lane;
    steps = 0;
    e = 0;
    n = sc + 1;
    sw = wbits(se);
    dw = wbits(de);
    if (vl > MAXVL) vl = MAXVL;
    for (int i = 0; i < vl; i++) begin
      if (!m[i]) begin
        steps++;
        continue;
      end
      acc = '0;
      for (int j = 0; j < n; j++) begin
        steps++;
        ra = up ? sb + i : sb + i * n + j;
        wa = up ? db + i * n + j : db + i;
        if (ra >= NREG || wa >= NREG) begin
          e = 1;
          return;
        end
        if (up) begin
          lane = 32'(64'(exp_rf[ra]) >> (j * sw));
          exp_rf[wa] = ref_conv(lane, sw, dw, sat);
        end else begin
          acc = acc | 32'(64'(ref_conv(exp_rf[ra], sw, dw, sat)) << (j * dw));
        end
      end
      if (!up) exp_rf[db + i] = acc;
    end
  endtask

  task automatic fill_rf();
    for (int k = 0; k < NREG; k++) begin
      rf[k] = $urandom;
      exp_rf[k] = rf[k];
    end
  endtask

  task automatic run_op(input string tag, input int up, input int sb, input int db,
                        input int vl, input int sc, input int se, input int de,
                        input logic [15:0] m, input int sat, input bit poke);
    int exp_steps;
    bit exp_err;
    int cnt;
    int guard;
    int first_bad;
    ref_run(up, sb, db, vl, sc, se, de, m, sat, exp_steps, exp_err);
    @(negedge clk);
    unpack = up[0]; src_base = 5'(sb); dst_base = 5'(db); vec_len = 5'(vl);
    subvl_m1 = 2'(sc); src_ew = 2'(se); dst_ew = 2'(de); pred_mask = m;
    sat_mode = 2'(sat); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    guard = 0;
    while (!done && guard < 200) begin
      if (busy) cnt++;
      if (poke && busy && guard == 0) begin
        // R10: second start and changed fields while running
        start = 1'b1; unpack = ~unpack; src_base = 5'd0; dst_base = 5'd0;
        vec_len = 5'd16; pred_mask = '1; sat_mode = 2'd2;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    chk(guard < 200, tag, "done seen", guard, 200);
    chk(cnt == exp_steps, tag, "busy cycles", cnt, exp_steps);
    chk(err == exp_err, tag, "err flag", err, exp_err);
    first_bad = -1;
    for (int k = NREG - 1; k >= 0; k--) if (rf[k] !== exp_rf[k]) first_bad = k;
    if (first_bad < 0) chk(1, tag, "register file", 0, 0);
    else chk(0, tag, $sformatf("register %0d", first_bad), rf[first_bad], exp_rf[first_bad]);
    @(negedge clk);
  endtask

  initial begin
    #(10 * 150000);
    chk(0, "WATCHDOG", "run time", 1, 0);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int up;
    int sc;
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < NREG; k++) begin rf[k] = '0; exp_rf[k] = '0; end
    repeat (3) @(negedge clk);
    // R1: quiet after reset
    chk(busy == 0 && done == 0 && err == 0 && rf_we == 0, "R1", "outputs in reset",
        {busy, done, err, rf_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0 && rf_we == 0, "R1", "outputs after reset",
        {busy, done, err, rf_we}, 0);

    // R2 R4: three byte lanes into one register, top byte zero
    fill_rf();
    rf[4] = 32'hAAAA_AA11; rf[5] = 32'hBBBB_BB22; rf[6] = 32'hCCCC_CC33;
    for (int k = 0; k < NREG; k++) exp_rf[k] = rf[k];
    run_op("R2", 0, 4, 10, 1, 2, 0, 0, 16'h0001, 0, 0);
    chk(rf[10] == 32'h0033_2211, "R2", "vec3 byte pack", rf[10], 32'h0033_2211);

    // R2: four byte lanes, two groups
    fill_rf();
    run_op("R2", 0, 0, 20, 2, 3, 0, 0, 16'h0003, 0, 0);

    // R3 R6: unpack two 16-bit lanes with signed clamp to bytes
    fill_rf();
    rf[3] = 32'h7FFF_8000; exp_rf[3] = rf[3];
    run_op("R3", 1, 3, 20, 1, 1, 1, 0, 16'h0001, 2, 0);
    chk(rf[20] == 32'h80, "R6", "signed clamp low", rf[20], 32'h80);
    chk(rf[21] == 32'h7F, "R6", "signed clamp high", rf[21], 32'h7F);

    // R4 R6: plain move, unsigned clamp 32 -> 8
    fill_rf();
    rf[7] = 32'h0000_01FF; exp_rf[7] = rf[7];
    run_op("R4", 0, 7, 9, 1, 0, 2, 0, 16'h0001, 1, 0);
    chk(rf[9] == 32'hFF, "R6", "unsigned clamp", rf[9], 32'hFF);

    // R5: widening without saturation zero-extends
    fill_rf();
    rf[1] = 32'h1234_5690; exp_rf[1] = rf[1];
    run_op("R5", 0, 1, 2, 1, 0, 0, 2, 16'h0001, 0, 0);
    chk(rf[2] == 32'h90, "R5", "zero extend", rf[2], 32'h90);

    // R6: signed widening sign-extends
    fill_rf();
    rf[1] = 32'h0000_00F0; exp_rf[1] = rf[1];
    run_op("R6", 0, 1, 2, 1, 0, 0, 1, 16'h0001, 2, 0);
    chk(rf[2] == 32'hFFF0, "R6", "sign extend", rf[2], 32'hFFF0);

    // R7: skipped groups keep their destinations
    fill_rf();
    exp_rf[13] = rf[13];
    run_op("R7", 0, 0, 12, 4, 1, 0, 0, 16'h0005, 0, 0);
    chk(rf[13] == exp_rf[13], "R7", "skipped dest unchanged", rf[13], exp_rf[13]);

    // R9: source index runs past the end
    fill_rf();
    run_op("R9", 0, 28, 0, 3, 3, 0, 0, 16'hFFFF, 0, 0);
    // R9: err cleared by the next accepted start
    fill_rf();
    run_op("R9", 1, 0, 8, 2, 1, 1, 1, 16'hFFFF, 0, 0);

    // R8: zero-length run
    fill_rf();
    run_op("R8", 0, 0, 0, 0, 0, 0, 0, 16'hFFFF, 0, 0);

    // R11: length above the maximum
    fill_rf();
    run_op("R11", 0, 0, 16, 20, 0, 2, 2, 16'hFFFF, 0, 0);

    // R10: start and field changes during a run have no effect
    fill_rf();
    run_op("R10", 0, 2, 18, 3, 2, 0, 1, 16'h0007, 0, 1);

    // R3: 32-bit source with 2 lanes, second lane reads zero
    fill_rf();
    run_op("R3", 1, 5, 6, 2, 1, 2, 2, 16'h0003, 0, 0);

    // R8 R2 R3: constrained random mix
    for (int t = 0; t < 60; t++) begin
      fill_rf();
      up = $urandom_range(0, 1);
      sc = $urandom_range(0, 3);
      run_op("R8", up,
             ($urandom_range(0, 3) == 0) ? $urandom_range(0, 31) : $urandom_range(0, 8),
             ($urandom_range(0, 3) == 0) ? $urandom_range(0, 31) : $urandom_range(8, 16),
             $urandom_range(0, 6), sc, $urandom_range(0, 3), $urandom_range(0, 3),
             16'($urandom), $urandom_range(0, 3), ($urandom_range(0, 4) == 0));
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule